// File: doc/BRIEF.md
# Descriptor Ring DMA Executor

This block is one DMA channel that works through a circular ring of 128-bit descriptors kept in memory. Software writes descriptors into ring slots, then moves a head index forward. The engine fetches and executes every slot from its own tail index up to that head. It then advances the tail, which software reads to see which slots it may reuse.

There are two descriptor kinds. A copy descriptor moves a block of 64-byte units from a source address to a destination address, one 64-bit word at a time. A status descriptor writes a 64-bit immediate to a destination address and can pulse an interrupt once that write has landed. Rewriting the head with the value it already holds counts as a ring-overrun error, and so does an unknown descriptor type. Either error sets a sticky flag that halts fetching until the channel is disabled or reset. Memory is reached through one request/acknowledge port that serves both reads and writes.

Top module: `dring_exec`

## Requirements
- R1: After reset, tail_idx is 0, err is 0, irq is 0 and mem_req is 0. No memory request is made while tail_idx equals the head index.
- R2: Descriptor slot i occupies two 64-bit words, the first at ring_base + 16*i and the second at ring_base + 16*i + 8. The type code sits in bits 63:60 of the second word, where 1 means copy and 2 means status.
- R3: A copy takes its source from the low AW bits of the first word and its destination from the low AW bits of the second word. Its length is in bits 63:46 of the first word, counted in 64-byte units. It moves length*8 consecutive 64-bit words. A length of zero writes nothing.
- R4: A status descriptor writes the whole first word to the address held in the low AW bits of the second word.
- R5: A status descriptor with bit 59 of its second word set raises irq for exactly one cycle after its write completes. Any other descriptor raises no irq.
- R6: tail_idx advances by one, modulo RING, after each completed descriptor. It stops when it equals the head index and wraps from RING-1 to 0.
- R7: While enable is high, a head write whose value equals the current head index sets err.
- R8: A descriptor whose type code is neither 1 nor 2 sets err, writes nothing to memory and leaves tail_idx on that slot.
- R9: While err is set, no new descriptor is fetched. Driving enable low clears err, and fetching resumes once enable is high again.
- R10: Once mem_req is raised, it stays high with mem_addr and mem_we unchanged until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel run enable; low clears the error flag |
| ring_base | input | AW | Byte address of ring slot 0 |
| head_wr | input | 1 | One-cycle strobe that loads head_val as the new head index |
| head_val | input | log2(RING) | New head index |
| tail_idx | output | log2(RING) | Index of the next slot to execute |
| err | output | 1 | Sticky error flag |
| irq | output | 1 | One-cycle interrupt pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 64 | Read data |

## Verification
The bench tests a zero-length copy. An engine that decremented before testing the count would run on through a huge block, which the bench catches as extra writes. It also fills a sentinel word just past a copy, so a copy that went one word too long would overwrite it. The bench runs the ring past slot RING-1 and checks that the tail wraps to 0 rather than running off the end. A second write of an unchanged head must set the flag, and the bench checks that the engine then stays quiet on newly posted work until a disable and enable. An unknown descriptor type is expected to write nothing and stay on its slot. The memory model stalls at random, which exposes any request that drops or changes address before it is acknowledged.

// File: rtl/dring_pkg.sv
package dring_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_DEC, S_CP_RD, S_CP_WR, S_ST_WR, S_DONE
  } eng_state_e;

  localparam logic [3:0] KIND_COPY = 4'd1;
  localparam logic [3:0] KIND_STAT = 4'd2;
  localparam int TYPE_LSB = 60;
  localparam int INTR_BIT = 59;
  localparam int LEN_LSB  = 46;
  localparam int LEN_W    = 64 - LEN_LSB;
  localparam int CNT_W    = LEN_W + 3;

  // next ring index, modulo size
  function automatic int unsigned ring_next(int unsigned idx, int unsigned size);
    return (idx + 1 >= size) ? 0 : idx + 1;
  endfunction

  // 64-byte units to 8-byte words
  function automatic logic [CNT_W-1:0] unit_to_words(logic [LEN_W-1:0] units);
    return {units, 3'b000};
  endfunction

endpackage

// File: rtl/dring_headreg.sv
module dring_headreg #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_wr,
  input  logic [IDX_W-1:0] head_val,
  output logic [IDX_W-1:0] head,
  output logic             ovw
);

  always_ff @(posedge clk) begin
    if (!rst_n)       head <= '0;
    else if (head_wr) head <= head_val;
  end

  // rewriting the same head implies a full-ring overwrite
  assign ovw = head_wr && (head_val == head);

endmodule

// File: rtl/dring_engine.sv
module dring_engine
  import dring_pkg::*;
#(
  parameter int RING  = 128,
  parameter int AW    = 32,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             err,
  input  logic [AW-1:0]    ring_base,
  input  logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             bad_type,
  output logic             desc_done,
  output logic             irq,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [63:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [63:0]      mem_rdata
);

  eng_state_e       state;
  logic [63:0]      qw0, qw1, dbuf;
  logic [CNT_W-1:0] widx, nwords;
  logic [3:0]       kind;
  logic [AW-1:0]    slot_addr, word_off;
  logic             unused_fields;

  assign kind          = qw1[63:TYPE_LSB];
  assign nwords        = unit_to_words(qw0[63:LEN_LSB]);
  assign slot_addr     = ring_base + (AW'(tail) << 4);
  assign word_off      = AW'(widx) << 3;
  assign bad_type      = (state == S_DEC) && (kind != KIND_COPY) && (kind != KIND_STAT);
  assign desc_done     = (state == S_DONE);
  assign unused_fields = ^{qw0[LEN_LSB-1:0], qw1[INTR_BIT:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tail  <= '0;
      qw0   <= '0;
      qw1   <= '0;
      dbuf  <= '0;
      widx  <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        S_IDLE:  if (enable && !err && (tail != head)) state <= S_RD0;
        S_RD0:   if (mem_ack) begin qw0 <= mem_rdata; state <= S_RD1; end
        S_RD1:   if (mem_ack) begin qw1 <= mem_rdata; state <= S_DEC; end
        S_DEC: begin
          widx <= '0;
          case (kind)
            KIND_COPY: state <= (nwords == '0) ? S_DONE : S_CP_RD;
            KIND_STAT: state <= S_ST_WR;
            default:   state <= S_IDLE;
          endcase
        end
        S_CP_RD: if (mem_ack) begin dbuf <= mem_rdata; state <= S_CP_WR; end
        S_CP_WR: if (mem_ack) begin
          if (widx + 1'b1 == nwords) state <= S_DONE;
          else begin
            widx  <= widx + 1'b1;
            state <= S_CP_RD;
          end
        end
        S_ST_WR: if (mem_ack) state <= S_DONE;
        S_DONE: begin
          tail  <= IDX_W'(ring_next(32'(tail), RING));
          irq   <= (kind == KIND_STAT) && qw1[INTR_BIT];
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_RD0:   begin mem_req = 1'b1; mem_addr = slot_addr; end
      S_RD1:   begin mem_req = 1'b1; mem_addr = slot_addr + AW'(8); end
      S_CP_RD: begin mem_req = 1'b1; mem_addr = qw0[AW-1:0] + word_off; end
      S_CP_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = qw1[AW-1:0] + word_off; mem_wdata = dbuf;
      end
      S_ST_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = qw1[AW-1:0]; mem_wdata = qw0;
      end
      default: ;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
  AST_HALT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) && err |=> (state == S_IDLE)); // R9
  AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_done |=> $stable(tail)); // R6
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_type |=> !mem_req); // R8
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(desc_done)); // R5

endmodule

// File: rtl/dring_exec.sv
module dring_exec
  import dring_pkg::*;
#(
  parameter  int RING  = 128,
  parameter  int AW    = 32,
  localparam int IDX_W = $clog2(RING)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [AW-1:0]    ring_base,
  input  logic             head_wr,
  input  logic [IDX_W-1:0] head_val,
  output logic [IDX_W-1:0] tail_idx,
  output logic             err,
  output logic             irq,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [63:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [63:0]      mem_rdata
);

  logic [IDX_W-1:0] head;
  logic             ovw, bad_type, desc_done;

  dring_headreg #(.IDX_W(IDX_W)) u_head (
    .clk(clk), .rst_n(rst_n), .head_wr(head_wr), .head_val(head_val),
    .head(head), .ovw(ovw)
  );

  dring_engine #(.RING(RING), .AW(AW), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .enable(enable), .err(err),
    .ring_base(ring_base), .head(head), .tail(tail_idx),
    .bad_type(bad_type), .desc_done(desc_done), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // sticky error; disabling the channel clears it
  always_ff @(posedge clk) begin
    if (!rst_n)                err <= 1'b0;
    else if (!enable)          err <= 1'b0;
    else if (ovw || bad_type)  err <= 1'b1;
  end

  AST_OVW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovw && enable |=> err); // R7
  AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bad_type && enable |=> err); // R8

endmodule

// File: tb/test_dring_exec.sv
`timescale 1ns/1ps
module test_dring_exec;

  localparam int RING = 128;
  localparam int AW   = 32;
  localparam int IW   = 7;

  logic          clk = 1'b0;
  logic          rst_n, enable, head_wr, irq, err;
  logic [AW-1:0] ring_base;
  logic [IW-1:0] head_val, tail_idx;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  dring_exec #(.RING(RING), .AW(AW)) i_dring_exec (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ring_base(ring_base),
    .head_wr(head_wr), .head_val(head_val), .tail_idx(tail_idx),
    .err(err), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  logic [63:0] mem [8192];
  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, irq_cnt = 0, req_cnt = 0, viol = 0;
  int exp_irq = 0;
  int hd = 0;
  logic          pend = 1'b0;
  logic [AW-1:0] paddr = '0;

  int          r_kind [20];
  logic [31:0] r_src [20], r_dst [20], r_units [20];
  logic [63:0] r_val [20];
  logic [63:0] wrap_exp [RING];

  function automatic int widx(logic [31:0] a);
    return int'(a[15:3]);
  endfunction

  function automatic logic [63:0] mk_q0_copy(logic [31:0] src, logic [31:0] units);
    return (64'(units) << 46) | 64'(src);
  endfunction

  function automatic logic [63:0] mk_q1(logic [3:0] kind, bit intr, logic [31:0] dst);
    return (64'(kind) << 60) | (64'(intr) << 59) | 64'(dst);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int slot, input logic [63:0] q0, input logic [63:0] q1);
    mem[slot*2]     = q0;
    mem[slot*2 + 1] = q1;
  endtask

  task automatic push_head(input int v);
    @(negedge clk);
    head_wr  = 1'b1;
    head_val = IW'(v);
    @(negedge clk);
    head_wr  = 1'b0;
  endtask

  task automatic wait_tail(input int target);
    int n = 0;
    while (int'(tail_idx) != target && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk(1'b0, "R6 tail timeout", 64'(tail_idx), 64'(target));
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic stimulus;
    int s, nb, tot, slot;
    logic [63:0] v;
    rst_n = 1'b0; enable = 1'b0; head_wr = 1'b0; head_val = '0; ring_base = '0;
    for (int i = 0; i < 8192; i++) mem[i] = 64'(i) ^ 64'h5A5A_0000_0000_0000;
    for (int i = widx(32'h2000); i < widx(32'h3000); i++) mem[i] = {$urandom, $urandom};
    for (int i = widx(32'h3000); i < widx(32'h8000); i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tail_idx == 0, "R1 tail reset", 64'(tail_idx), 0);
    chk(err == 0, "R1 err reset", 64'(err), 0);
    chk(irq == 0, "R1 irq reset", 64'(irq), 0);
    chk(mem_req == 0, "R1 req reset", 64'(mem_req), 0);
    enable = 1'b1;
    repeat (10) @(negedge clk);
    chk(req_cnt == 0, "R1 no fetch when tail==head", 64'(req_cnt), 0);

    // status without interrupt
    put_desc(0, 64'h1111_2222_3333_4444, mk_q1(4'd2, 1'b0, 32'h4000));
    hd = 1; push_head(hd); wait_tail(1);
    chk(mem[widx(32'h4000)] == 64'h1111_2222_3333_4444, "R4 status write",
        mem[widx(32'h4000)], 64'h1111_2222_3333_4444);
    chk(irq_cnt == 0, "R5 no irq without bit59", 64'(irq_cnt), 0);

    // status with interrupt
    put_desc(1, 64'hDEAD_BEEF_0000_0001, mk_q1(4'd2, 1'b1, 32'h4008));
    exp_irq++;
    hd = 2; push_head(hd); wait_tail(2);
    chk(mem[widx(32'h4008)] == 64'hDEAD_BEEF_0000_0001, "R2 slot1 fetch/status",
        mem[widx(32'h4008)], 64'hDEAD_BEEF_0000_0001);
    chk(irq_cnt == exp_irq, "R5 irq on bit59", 64'(irq_cnt), 64'(exp_irq));

    // copy of 2 units with sentinel just beyond
    mem[widx(32'h3080)] = 64'hFEED_FACE_CAFE_0000;
    put_desc(2, mk_q0_copy(32'h2000, 2), mk_q1(4'd1, 1'b0, 32'h3000));
    hd = 3; push_head(hd); wait_tail(3);
    s = 0;
    for (int i = 0; i < 16; i++)
      if (mem[widx(32'h3000) + i] != mem[widx(32'h2000) + i]) s++;
    chk(s == 0, "R3 copy 2 units", 64'(s), 0);
    chk(mem[widx(32'h3080)] == 64'hFEED_FACE_CAFE_0000, "R3 copy stops at length",
        mem[widx(32'h3080)], 64'hFEED_FACE_CAFE_0000);

    // zero-length copy
    s = wr_cnt;
    put_desc(3, mk_q0_copy(32'h2000, 0), mk_q1(4'd1, 1'b0, 32'h3800));
    hd = 4; push_head(hd); wait_tail(4);
    chk(wr_cnt == s, "R3 zero length writes nothing", 64'(wr_cnt), 64'(s));
    chk(tail_idx == 4, "R6 tail after zero copy", 64'(tail_idx), 4);

    // random mix in batches
    tot = 0;
    while (tot < 20) begin
      nb = $urandom_range(1, 5);
      if (nb > 20 - tot) nb = 20 - tot;
      for (int j = 0; j < nb; j++) begin
        int k = tot + j;
        if ($urandom_range(0, 1) == 1) begin
          r_kind[k]  = 1;
          r_src[k]   = 32'h2000 + 32'($urandom_range(0, 31)) * 64;
          r_units[k] = 32'($urandom_range(1, 3));
          r_dst[k]   = 32'h6000 + 32'(k) * 32'h100;
          put_desc(hd + j, mk_q0_copy(r_src[k], r_units[k]), mk_q1(4'd1, 1'b0, r_dst[k]));
        end else begin
          bit ir = 1'($urandom_range(0, 1));
          r_kind[k] = 2;
          r_val[k]  = {$urandom, $urandom};
          r_dst[k]  = 32'h5000 + 32'(k) * 8;
          if (ir) exp_irq++;
          put_desc(hd + j, r_val[k], mk_q1(4'd2, ir, r_dst[k]));
        end
      end
      tot += nb;
      hd += nb;
      push_head(hd);
      wait_tail(hd);
    end
    for (int k = 0; k < 20; k++) begin
      if (r_kind[k] == 1) begin
        s = 0;
        for (int i = 0; i < int'(r_units[k]) * 8; i++)
          if (mem[widx(r_dst[k]) + i] != mem[widx(r_src[k]) + i]) s++;
        chk(s == 0, "R3 random copy", 64'(s), 0);
      end else begin
        chk(mem[widx(r_dst[k])] == r_val[k], "R4 random status", mem[widx(r_dst[k])], r_val[k]);
      end
    end
    chk(irq_cnt == exp_irq, "R5 random irq count", 64'(irq_cnt), 64'(exp_irq));

    // same head rewritten
    push_head(hd);
    chk(err == 1, "R7 same head sets err", 64'(err), 1);
    put_desc(hd, 64'h0BAD_0BAD_0BAD_0BAD, mk_q1(4'd2, 1'b0, 32'h4100));
    slot = hd;
    hd++; push_head(hd);
    repeat (60) @(negedge clk);
    chk(int'(tail_idx) == slot, "R9 halted while err", 64'(tail_idx), 64'(slot));
    chk(mem[widx(32'h4100)] == 0, "R9 no write while err", mem[widx(32'h4100)], 0);
    enable = 1'b0;
    @(negedge clk);
    chk(err == 0, "R9 disable clears err", 64'(err), 0);
    enable = 1'b1;
    wait_tail(hd);
    chk(mem[widx(32'h4100)] == 64'h0BAD_0BAD_0BAD_0BAD, "R9 resumes after enable",
        mem[widx(32'h4100)], 64'h0BAD_0BAD_0BAD_0BAD);

    // unknown type code 3
    s = wr_cnt;
    slot = hd;
    put_desc(hd, 64'h7777_7777_7777_7777, mk_q1(4'd3, 1'b0, 32'h4200));
    hd++; push_head(hd);
    repeat (40) @(negedge clk);
    chk(err == 1, "R8 unknown type sets err", 64'(err), 1);
    chk(int'(tail_idx) == slot, "R8 tail stays on bad slot", 64'(tail_idx), 64'(slot));
    chk(wr_cnt == s, "R8 no memory write", 64'(wr_cnt), 64'(s));
    enable = 1'b0;
    put_desc(slot, 64'h8888_8888_8888_8888, mk_q1(4'd2, 1'b0, 32'h4200));
    @(negedge clk);
    enable = 1'b1;
    wait_tail(hd);
    chk(mem[widx(32'h4200)] == 64'h8888_8888_8888_8888, "R8 repaired slot executes",
        mem[widx(32'h4200)], 64'h8888_8888_8888_8888);

    // run past the end of the ring
    tot = (RING - hd) + 5;
    s = 0;
    while (tot > 0) begin
      nb = (tot > 16) ? 16 : tot;
      for (int j = 0; j < nb; j++) begin
        slot = (hd + j) % RING;
        v = 64'hAB00_0000_0000_0000 | 64'(s);
        s++;
        wrap_exp[slot] = v;
        put_desc(slot, v, mk_q1(4'd2, 1'b0, 32'h4800 + 32'(slot) * 8));
      end
      hd = (hd + nb) % RING;
      tot -= nb;
      push_head(hd);
      wait_tail(hd);
    end
    chk(tail_idx == 5, "R6 tail wrapped", 64'(tail_idx), 5);
    chk(mem[widx(32'h4800 + 127*8)] == wrap_exp[127], "R6 last slot executed",
        mem[widx(32'h4800 + 127*8)], wrap_exp[127]);
    chk(mem[widx(32'h4800)] == wrap_exp[0], "R6 slot0 after wrap",
        mem[widx(32'h4800)], wrap_exp[0]);
    chk(mem[widx(32'h4800 + 4*8)] == wrap_exp[4], "R6 slot4 after wrap",
        mem[widx(32'h4800 + 4*8)], wrap_exp[4]);
    chk(viol == 0, "R10 request held until ack", 64'(viol), 0);
    summary();
  endtask

  initial begin
    void'($urandom(32'd1234));
    mem_ack   = 1'b0;
    mem_rdata = '0;
    fork
      stimulus();
      forever begin
        @(posedge clk);
        if (rst_n && irq) irq_cnt++;
        if (rst_n && mem_req) req_cnt++;
        if (rst_n && pend && (!mem_req || mem_addr != paddr)) viol++;
        pend  <= rst_n && mem_req && !mem_ack;
        paddr <= mem_addr;
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_ack) mem_ack <= 1'b0;
        else if (mem_req && $urandom_range(0, 3) != 0) begin
          mem_ack <= 1'b1;
          if (mem_we) begin
            mem[widx(mem_addr)] <= mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata <= mem[widx(mem_addr)];
          end
        end
      end
      begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
      end
    join_any
  end

endmodule